// File: doc/BRIEF.md
# Compare-Match Timer Output Unit

This block is a 16-bit up-counter with two comparators that drives a single output pin in compare-match fashion. The duty comparator matches the full counter against a 16-bit value. The period comparator takes a 3-bit value that stands for the counter's top three bits, with the lower thirteen bits zero. A clear-select input picks which comparator restarts the count. A compare value of zero on the selected comparator lets the counter run through 0xFFFF and wrap instead.

Each comparator raises a sticky request flag, and software drops each flag with its own clear strobe. Only duty matches move the pin. A two-bit action code sets what the pin does on a duty match: hold, drive low, drive high or toggle. When the enable rises, the pin is loaded with an initial level and the count restarts from zero. A polarity input inverts the level seen at the pin. A pause input freezes the count so that it can resume from where it stopped.

Top module: `cmp_match_timer`

## Requirements
- R1: While reset is asserted and after it is released, with enable low and polarity low, the pin reads 0 and both flags read 0.
- R2: With clear-select 0 and a nonzero period value V, the counter returns to 0 on the clock after it equals V·8192, and the period flag is set on that same clock. Duty matches keep raising the duty flag in this setting.
- R3: With clear-select 0 and period value 0, the counter is never cleared by the period comparator. It passes 0xFFFF, wraps to 0, and meets the duty value again 65536 clocks after the previous duty match. The period flag stays 0.
- R4: With clear-select 1, the counter returns to 0 on the clock after it equals a nonzero duty value. The period flag is never set, even when V·8192 is below the duty value.
- R5: With clear-select 1 and a duty value of 0, the counter runs through 0xFFFF and wraps. The duty flag is never set and the pin never moves.
- R6: A duty match is counted on the clock edge at which the counter equals the duty value while running. The flag and the pin reflect the match right after that edge. The action code is 00 hold, 01 drive low, 10 drive high, 11 toggle. Period matches never move the pin.
- R7: When polarity is 1, the pin shows the inverse of the internal level, and the change follows immediately.
- R8: On the clock edge where enable is sampled high after being low, the internal level is loaded with the initial-level input and the counter becomes 0. The first duty match then follows at edge duty+1 counted from that edge.
- R9: While pause is high, the counter holds its value. When pause falls, counting resumes from the held value.
- R10: While enable is low, the counter holds and no match is counted.
- R11: Each flag stays set until its own clear strobe. A set event and a clear strobe on the same edge leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable; a rising edge restarts the count and loads the pin level |
| pause_i | input | 1 | Freezes the counter while high |
| clr_sel_i | input | 1 | 0: period comparator clears the count; 1: duty comparator clears it |
| act_i | input | 2 | Pin action on a duty match (00 hold, 01 low, 10 high, 11 toggle) |
| init_lvl_i | input | 1 | Level loaded into the pin on an enable rise |
| pol_i | input | 1 | Inverts the pin when high |
| per_cmp_i | input | 3 | Period value; compared with counter bits [15:13] |
| duty_cmp_i | input | 16 | Duty value; compared with the full counter |
| clr_aflag_i | input | 1 | Clear strobe for the duty flag |
| clr_pflag_i | input | 1 | Clear strobe for the period flag |
| pin_o | output | 1 | Output pin level |
| aflag_o | output | 1 | Sticky duty-match flag |
| pflag_o | output | 1 | Sticky period-match flag |

## Verification
A duty match that sets the flag can land on the same edge as software's clear strobe for that flag. The set must win. To provoke this, the bench counts edges from an enable rise and holds the clear strobe high across exactly the edge where the second duty match of a period falls. The flag must read 1 after that edge, and the toggled pin must show that the match was taken in that same cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_DUTY = 0;
    localparam int unsigned FLAG_PER  = 1;

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pause_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_rise_o,
    output logic             run_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t st_d, st_q;
    logic       rise;
    logic       run;

    always_comb begin
        rise       = en_i & ~st_q.en_prev;
        run        = en_i & ~pause_i & ~rise;
        st_d       = st_q;
        st_d.en_prev = en_i;
        if (rise) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (clear_i) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign en_rise_o = rise;
    assign run_o     = run;

endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PER_W = 3
) (
    input  logic             run_i,
    input  logic             clr_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [PER_W-1:0] per_cmp_i,
    input  logic [CNT_W-1:0] duty_cmp_i,
    output logic             a_evt_o,
    output logic             p_evt_o,
    output logic             clear_o
);

    localparam int unsigned LOW_W = CNT_W - PER_W;

    logic per_hit;
    logic duty_hit;
    logic per_zero;
    logic duty_zero;

    always_comb begin
        per_zero  = (per_cmp_i == '0);
        duty_zero = (duty_cmp_i == '0);
        per_hit   = !per_zero
                    && (cnt_i[CNT_W-1 -: PER_W] == per_cmp_i)
                    && (cnt_i[LOW_W-1:0] == '0);
        duty_hit  = (cnt_i == duty_cmp_i);

        a_evt_o   = run_i && duty_hit && !(clr_sel_i && duty_zero);
        p_evt_o   = run_i && per_hit && !clr_sel_i;
        clear_o   = clr_sel_i ? a_evt_o : p_evt_o;
    end

endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_rise_i,
    input  logic       a_evt_i,
    input  logic [1:0] act_i,
    input  logic       init_lvl_i,
    input  logic       pol_i,
    output logic       pin_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (en_rise_i) begin
            lvl_d = init_lvl_i;
        end else if (a_evt_i) begin
            unique case (pin_act_e'(act_i))
                ACT_HOLD:   lvl_d = lvl_q;
                ACT_LOW:    lvl_d = 1'b0;
                ACT_HIGH:   lvl_d = 1'b1;
                ACT_TOGGLE: lvl_d = ~lvl_q;
                default:    lvl_d = lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign pin_o = lvl_q ^ pol_i;

endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer
    import cmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pause_i,
    input  logic             clr_sel_i,
    input  logic [1:0]       act_i,
    input  logic             init_lvl_i,
    input  logic             pol_i,
    input  logic [PER_W-1:0] per_cmp_i,
    input  logic [CNT_W-1:0] duty_cmp_i,
    input  logic             clr_aflag_i,
    input  logic             clr_pflag_i,
    output logic             pin_o,
    output logic             aflag_o,
    output logic             pflag_o
);

    logic [CNT_W-1:0]     cnt_q;
    logic                 en_rise;
    logic                 run;
    logic                 a_evt;
    logic                 p_evt;
    logic                 clear;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    cmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .pause_i   (pause_i),
        .clear_i   (clear),
        .cnt_o     (cnt_q),
        .en_rise_o (en_rise),
        .run_o     (run)
    );

    cmt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_compare (
        .run_i      (run),
        .clr_sel_i  (clr_sel_i),
        .cnt_i      (cnt_q),
        .per_cmp_i  (per_cmp_i),
        .duty_cmp_i (duty_cmp_i),
        .a_evt_o    (a_evt),
        .p_evt_o    (p_evt),
        .clear_o    (clear)
    );

    cmt_pin u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rise_i  (en_rise),
        .a_evt_i    (a_evt),
        .act_i      (act_i),
        .init_lvl_i (init_lvl_i),
        .pol_i      (pol_i),
        .pin_o      (pin_o)
    );

    assign flag_set[FLAG_DUTY] = a_evt;
    assign flag_set[FLAG_PER]  = p_evt;
    assign flag_clr[FLAG_DUTY] = clr_aflag_i;
    assign flag_clr[FLAG_PER]  = clr_pflag_i;

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        cmt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[gi]),
            .clr_i  (flag_clr[gi]),
            .flag_o (flag_q[gi])
        );
    end

    assign aflag_o = flag_q[FLAG_DUTY];
    assign pflag_o = flag_q[FLAG_PER];

endmodule

// File: rtl/cmp_match_timer_chk.sv
module cmp_match_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             pause_i,
    input logic             clr_sel_i,
    input logic [1:0]       act_i,
    input logic             init_lvl_i,
    input logic             pol_i,
    input logic [CNT_W-1:0] duty_cmp_i,
    input logic             clr_aflag_i,
    input logic             clr_pflag_i,
    input logic             pin_o,
    input logic             aflag_o,
    input logic             pflag_o,
    input logic             en_rise,
    input logic             a_evt,
    input logic [CNT_W-1:0] cnt_q
);

    p_pflag_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel_i && !pflag_o) |=> !pflag_o);

    p_no_aflag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel_i && duty_cmp_i == '0 && !aflag_o) |=> !aflag_o);

    p_pin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_evt && !en_rise) |=> ((pin_o ^ pol_i) == $past(pin_o ^ pol_i)));

    p_drive_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_evt && act_i == 2'b10) |=> (pin_o ^ pol_i));

    p_rise_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> ((pin_o ^ pol_i) == $past(init_lvl_i)) && (cnt_q == '0));

    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pause_i && !en_rise) |=> (cnt_q == $past(cnt_q)));

    p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == $past(cnt_q)));

    p_aflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (aflag_o && !clr_aflag_i) |=> aflag_o);

    p_pflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pflag_o && !clr_pflag_i) |=> pflag_o);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        a_evt |=> aflag_o);

endmodule

bind cmp_match_timer cmp_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .pause_i     (pause_i),
    .clr_sel_i   (clr_sel_i),
    .act_i       (act_i),
    .init_lvl_i  (init_lvl_i),
    .pol_i       (pol_i),
    .duty_cmp_i  (duty_cmp_i),
    .clr_aflag_i (clr_aflag_i),
    .clr_pflag_i (clr_pflag_i),
    .pin_o       (pin_o),
    .aflag_o     (aflag_o),
    .pflag_o     (pflag_o),
    .en_rise     (en_rise),
    .a_evt       (a_evt),
    .cnt_q       (cnt_q)
);

// File: tb/cmp_match_timer_bench.sv
`timescale 1ns/1ps
module cmp_match_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        pause_i = 1'b0;
    logic        clr_sel_i = 1'b0;
    logic [1:0]  act_i = 2'b00;
    logic        init_lvl_i = 1'b0;
    logic        pol_i = 1'b0;
    logic [2:0]  per_cmp_i = 3'd0;
    logic [15:0] duty_cmp_i = 16'd0;
    logic        clr_aflag_i = 1'b0;
    logic        clr_pflag_i = 1'b0;
    logic        pin_o;
    logic        aflag_o;
    logic        pflag_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_match_timer u_cmp_match_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .pause_i     (pause_i),
        .clr_sel_i   (clr_sel_i),
        .act_i       (act_i),
        .init_lvl_i  (init_lvl_i),
        .pol_i       (pol_i),
        .per_cmp_i   (per_cmp_i),
        .duty_cmp_i  (duty_cmp_i),
        .clr_aflag_i (clr_aflag_i),
        .clr_pflag_i (clr_pflag_i),
        .pin_o       (pin_o),
        .aflag_o     (aflag_o),
        .pflag_o     (pflag_o)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Disable, wipe both flags, load settings, then raise enable across one edge (edge 0).
    task automatic start(input logic sel, input logic [2:0] per, input logic [15:0] duty,
                         input logic [1:0] act, input logic init);
        en_i = 1'b0; pause_i = 1'b0;
        clr_aflag_i = 1'b1; clr_pflag_i = 1'b1;
        step(1);
        clr_aflag_i = 1'b0; clr_pflag_i = 1'b0;
        clr_sel_i = sel; per_cmp_i = per; duty_cmp_i = duty;
        act_i = act; init_lvl_i = init;
        en_i = 1'b1;
        step(1);
    endtask

    task automatic t_reset;
        #3;
        chk("R1", "pin in reset", pin_o, 1'b0);
        chk("R1", "aflag in reset", aflag_o, 1'b0);
        chk("R1", "pflag in reset", pflag_o, 1'b0);
        step(2);
        rst_n = 1'b1;
        step(3);
        chk("R1", "pin after reset", pin_o, 1'b0);
        chk("R1", "pflag after reset", pflag_o, 1'b0);
    endtask

    task automatic t_period_clear;
        start(1'b0, 3'd1, 16'd5, 2'b11, 1'b0);
        step(5);
        chk("R6", "aflag before duty match", aflag_o, 1'b0);
        chk("R6", "pin before duty match", pin_o, 1'b0);
        step(1);
        chk("R2", "aflag at duty match", aflag_o, 1'b1);
        chk("R6", "pin toggled high", pin_o, 1'b1);
        clr_aflag_i = 1'b1; step(1); clr_aflag_i = 1'b0;
        chk("R11", "aflag cleared by strobe", aflag_o, 1'b0);
        step(16'h2001 - 8);
        chk("R2", "pflag before period match", pflag_o, 1'b0);
        step(1);
        chk("R2", "pflag at period match", pflag_o, 1'b1);
        chk("R6", "pin kept on period match", pin_o, 1'b1);
        step(5);
        chk("R2", "aflag before second duty match", aflag_o, 1'b0);
        clr_aflag_i = 1'b1;
        step(1);
        clr_aflag_i = 1'b0;
        chk("R11", "set wins over clear", aflag_o, 1'b1);
        chk("R2", "pin toggled back after counter clear", pin_o, 1'b0);
        chk("R11", "pflag still sticky", pflag_o, 1'b1);
    endtask

    task automatic t_duty_clear;
        start(1'b1, 3'd1, 16'h3000, 2'b10, 1'b0);
        step(16'h3000);
        chk("R4", "aflag before duty match", aflag_o, 1'b0);
        step(1);
        chk("R4", "aflag at duty match", aflag_o, 1'b1);
        chk("R6", "pin driven high", pin_o, 1'b1);
        chk("R4", "no pflag below duty", pflag_o, 1'b0);
        clr_aflag_i = 1'b1; step(1); clr_aflag_i = 1'b0;
        step(16'h2FFF);
        chk("R4", "aflag before next period", aflag_o, 1'b0);
        step(1);
        chk("R4", "aflag after duty-cleared period", aflag_o, 1'b1);
        chk("R4", "pflag never set", pflag_o, 1'b0);
    endtask

    task automatic t_duty_zero;
        start(1'b1, 3'd0, 16'd0, 2'b11, 1'b0);
        step(65600);
        chk("R5", "no aflag with duty zero", aflag_o, 1'b0);
        chk("R5", "pin unchanged", pin_o, 1'b0);
        chk("R5", "no pflag", pflag_o, 1'b0);
    endtask

    task automatic t_overflow_wrap;
        start(1'b0, 3'd0, 16'd3, 2'b11, 1'b0);
        step(4);
        chk("R3", "first duty match", aflag_o, 1'b1);
        clr_aflag_i = 1'b1; step(1); clr_aflag_i = 1'b0;
        step(65534);
        chk("R3", "no match before wrap", aflag_o, 1'b0);
        step(1);
        chk("R3", "duty match after wrap", aflag_o, 1'b1);
        chk("R3", "pflag stays 0", pflag_o, 1'b0);
    endtask

    task automatic t_actions;
        start(1'b0, 3'd1, 16'd2, 2'b01, 1'b1);
        chk("R8", "initial level 1 loaded", pin_o, 1'b1);
        step(2);
        chk("R6", "low action before match", pin_o, 1'b1);
        step(1);
        chk("R6", "low action drives 0", pin_o, 1'b0);
        start(1'b0, 3'd1, 16'd2, 2'b00, 1'b1);
        step(3);
        chk("R6", "hold action flag", aflag_o, 1'b1);
        chk("R6", "hold action keeps pin", pin_o, 1'b1);
        pol_i = 1'b1;
        #1;
        chk("R7", "polarity inverts pin", pin_o, 1'b0);
        start(1'b0, 3'd1, 16'd2, 2'b10, 1'b0);
        chk("R7", "inverted initial level", pin_o, 1'b1);
        step(3);
        chk("R7", "inverted high action", pin_o, 1'b0);
        pol_i = 1'b0;
        #1;
        chk("R6", "high action level", pin_o, 1'b1);
    endtask

    task automatic t_pause;
        start(1'b0, 3'd1, 16'd10, 2'b11, 1'b0);
        step(5);
        pause_i = 1'b1;
        step(20);
        chk("R9", "no match while paused", aflag_o, 1'b0);
        pause_i = 1'b0;
        step(5);
        chk("R9", "resumed, not yet at duty", aflag_o, 1'b0);
        step(1);
        chk("R9", "match after resume", aflag_o, 1'b1);
    endtask

    task automatic t_stop;
        start(1'b0, 3'd1, 16'd10, 2'b11, 1'b0);
        step(5);
        en_i = 1'b0;
        step(30);
        chk("R10", "no match while disabled", aflag_o, 1'b0);
        en_i = 1'b1;
        step(1);
        step(10);
        chk("R8", "restart from zero, not held value", aflag_o, 1'b0);
        step(1);
        chk("R8", "match at duty+1 after restart", aflag_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_actions();
        t_pause();
        t_stop();
        t_period_clear();
        t_duty_clear();
        t_duty_zero();
        t_overflow_wrap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule